// File: doc/BRIEF.md
# Arm Sub-Module Insertion Selector

This block decides which sub-modules of one converter arm are inserted and which are bypassed. A central controller supplies a capacitor voltage estimate for each sub-module, the polarity of the arm current, the insertion mask now applied, a mask of modules taken out of service, and the number of modules that should be inserted next. When an update strobe arrives, the block compares the requested count with the number already inserted. It changes the state of exactly that many modules and leaves every other module alone.

The modules that change are chosen by voltage rank, in a direction set by the arm current. When the current charges the capacitors, insertion takes the weakest bypassed modules and bypass takes the strongest inserted ones. When the current discharges them, the choice is mirrored. Because only the difference in count is applied, and the arm is not re-sorted on every update, the switching frequency stays low.

The search finds one module per clock cycle. An update therefore takes one more cycle than the number of modules that change. A single-cycle `sel_done` pulse marks the new mask.

Top module: `arm_insert_selector`

## Requirements
- R1: A `upd_stb` pulse is accepted only while the block is idle. `sel_done` then rises for exactly one cycle, |Δ|+1 clock edges after the accepting edge, where Δ is the clamped requested count minus the count of in-service modules set in `ins_mask_in`. A strobe that arrives while an update is running is ignored.
- R2: When Δ is zero, `ins_mask_out` equals `ins_mask_in` with the out-of-service bits cleared.
- R3: Δ>0 with `arm_cur_neg`=0 (arm current zero or positive) inserts the Δ bypassed in-service modules with the lowest voltages.
- R4: Δ>0 with `arm_cur_neg`=1 inserts the Δ bypassed in-service modules with the highest voltages.
- R5: Δ<0 with `arm_cur_neg`=0 bypasses the |Δ| inserted in-service modules with the highest voltages.
- R6: Δ<0 with `arm_cur_neg`=1 bypasses the |Δ| inserted in-service modules with the lowest voltages.
- R7: Among modules with equal voltage estimates, the lower module index is chosen first, in both search directions.
- R8: A module whose bit is set in `oos_mask` is never selected and always reads as bypassed (0) in `ins_mask_out`.
- R9: The requested count is clamped to the number of in-service modules, so the population of `ins_mask_out` equals min(`req_cnt`, in-service count).
- R10: After reset, `ins_mask_out` is all zeros and `sel_done` is low. `ins_mask_out` changes only in a cycle where `sel_done` is high.
- R11: Bit i of `ins_mask_out` differs from the in-service part of `ins_mask_in` for exactly |Δ| modules. All other modules keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upd_stb | input | 1 | Update strobe, one cycle |
| volt_est | input | N_MOD*VW | Packed voltage estimates; module i occupies bits [i*VW +: VW], unsigned |
| arm_cur_neg | input | 1 | 1 when arm current is negative; 0 for zero or positive |
| ins_mask_in | input | N_MOD | Present insertion mask, bit i = module i inserted |
| oos_mask | input | N_MOD | Out-of-service modules, bit i = module i unusable |
| req_cnt | input | $clog2(N_MOD+1) | Requested number of inserted modules |
| ins_mask_out | output | N_MOD | New insertion mask, held between updates |
| sel_done | output | 1 | One-cycle pulse when `ins_mask_out` is updated |

## Verification
A wrong latched working mask or a wrong out-of-service copy would appear at `ins_mask_out` on the `sel_done` pulse of that same update. It would show as a module set or cleared against the expected voltage rank. A wrong remaining-pick counter moves the `sel_done` pulse off the |Δ|+1 edge, or leaves the population of the mask wrong. A wrong search direction or tie rule would flip a specific bit on the very next update whose voltages separate the candidates.

// File: rtl/asel_pkg.sv
package asel_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } asel_state_e;

    // Search direction: 1 selects the highest voltage, 0 the lowest.
    // Growing with positive current takes the weakest; shrinking takes the strongest.
    function automatic logic pick_highest(input logic grow, input logic cur_neg);
        return (grow == cur_neg);
    endfunction

endpackage

// File: rtl/asel_count.sv
module asel_count #(
    parameter int N_MOD = 8,
    parameter int CW    = $clog2(N_MOD + 1)
) (
    input  logic [N_MOD-1:0] cur_mask,
    input  logic [N_MOD-1:0] oos_mask,
    input  logic [CW-1:0]    req_cnt,
    output logic [CW-1:0]    tgt_cnt,
    output logic [CW-1:0]    step_mag,
    output logic             grow
);
    logic [CW-1:0] old_cnt;
    logic [CW-1:0] oos_cnt;
    logic [CW-1:0] act_cnt;

    always_comb begin
        old_cnt = '0;
        oos_cnt = '0;
        for (int i = 0; i < N_MOD; i++) begin
            old_cnt = old_cnt + CW'(cur_mask[i] & ~oos_mask[i]);
            oos_cnt = oos_cnt + CW'(oos_mask[i]);
        end
        act_cnt  = CW'(N_MOD) - oos_cnt;
        tgt_cnt  = (req_cnt > act_cnt) ? act_cnt : req_cnt;
        grow     = (tgt_cnt > old_cnt);
        step_mag = grow ? (tgt_cnt - old_cnt) : (old_cnt - tgt_cnt);
    end
endmodule

// File: rtl/asel_extreme.sv
module asel_extreme #(
    parameter int N_MOD = 8,
    parameter int VW    = 12,
    parameter int IW    = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic [N_MOD-1:0][VW-1:0] volt,
    input  logic [N_MOD-1:0]         elig,
    input  logic                     find_max,
    output logic [IW-1:0]            pick_idx,
    output logic                     found
);
    logic [VW-1:0] best_v;

    // Strict comparison keeps the earliest index on equal voltages.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        best_v   = '0;
        for (int i = 0; i < N_MOD; i++) begin
            if (elig[i]) begin
                if (!found ||
                    ( find_max && (volt[i] > best_v)) ||
                    (!find_max && (volt[i] < best_v))) begin
                    found    = 1'b1;
                    pick_idx = IW'(i);
                    best_v   = volt[i];
                end
            end
        end
    end
endmodule

// File: rtl/arm_insert_selector.sv
module arm_insert_selector
    import asel_pkg::*;
#(
    parameter int N_MOD = 8,
    parameter int VW    = 12,
    localparam int CW   = $clog2(N_MOD + 1),
    localparam int IW   = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_stb,
    input  logic [N_MOD*VW-1:0]  volt_est,
    input  logic                 arm_cur_neg,
    input  logic [N_MOD-1:0]     ins_mask_in,
    input  logic [N_MOD-1:0]     oos_mask,
    input  logic [CW-1:0]        req_cnt,
    output logic [N_MOD-1:0]     ins_mask_out,
    output logic                 sel_done
);
    typedef struct packed {
        asel_state_e             st;
        logic [N_MOD-1:0]        work;
        logic [N_MOD-1:0][VW-1:0] volt;
        logic [N_MOD-1:0]        oos;
        logic                    neg;
        logic                    grow;
        logic [CW-1:0]           remain;
        logic [CW-1:0]           tgt;
        logic [N_MOD-1:0]        out;
        logic                    done;
    } sel_regs_t;

    sel_regs_t r_q, r_d;

    logic [N_MOD-1:0][VW-1:0] volt_in;
    logic [CW-1:0]            tgt_cnt;
    logic [CW-1:0]            step_mag;
    logic                     grow;
    logic [N_MOD-1:0]         elig;
    logic                     find_max;
    logic [IW-1:0]            pick_idx;
    logic                     found;

    assign volt_in = volt_est;

    asel_count #(.N_MOD(N_MOD), .CW(CW)) u_count (
        .cur_mask (ins_mask_in),
        .oos_mask (oos_mask),
        .req_cnt  (req_cnt),
        .tgt_cnt  (tgt_cnt),
        .step_mag (step_mag),
        .grow     (grow)
    );

    assign elig     = r_q.grow ? (~r_q.work & ~r_q.oos) : (r_q.work & ~r_q.oos);
    assign find_max = pick_highest(r_q.grow, r_q.neg);

    asel_extreme #(.N_MOD(N_MOD), .VW(VW), .IW(IW)) u_extreme (
        .volt     (r_q.volt),
        .elig     (elig),
        .find_max (find_max),
        .pick_idx (pick_idx),
        .found    (found)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            S_IDLE: begin
                if (upd_stb) begin
                    r_d.st     = S_RUN;
                    r_d.volt   = volt_in;
                    r_d.oos    = oos_mask;
                    r_d.neg    = arm_cur_neg;
                    r_d.work   = ins_mask_in & ~oos_mask;
                    r_d.grow   = grow;
                    r_d.remain = step_mag;
                    r_d.tgt    = tgt_cnt;
                end
            end
            S_RUN: begin
                if (r_q.remain == '0) begin
                    r_d.out  = r_q.work;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else if (found) begin
                    r_d.work[pick_idx] = ~r_q.work[pick_idx];
                    r_d.remain         = r_q.remain - 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ins_mask_out = r_q.out;
    assign sel_done     = r_q.done;

    // R1: the completion pulse lasts one cycle
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |=> !sel_done);

    // R1: each pass consumes exactly one pick
    p_remain_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RUN && r_q.remain != '0) |=> (r_q.remain == $past(r_q.remain) - 1'b1));

    // R8: the search always lands on an eligible module while picks remain
    p_pick_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RUN && r_q.remain != '0) |-> (found && elig[pick_idx]));

    // R8: out-of-service modules never appear inserted
    p_oos_bypassed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |-> ((ins_mask_out & r_q.oos) == '0));

    // R9: the output population matches the clamped target
    p_count_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_done |-> ($countones(ins_mask_out) == int'(r_q.tgt)));

    // R10: the output mask only moves together with the done pulse
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_done |=> (!sel_done || 1'b1) && ($changed(ins_mask_out) -> sel_done));
endmodule

// File: tb/sim_arm_insert_selector.sv
module sim_arm_insert_selector;
    localparam int N  = 8;
    localparam int VW = 12;
    localparam int CW = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              upd_stb = 1'b0;
    logic [N*VW-1:0]   volt_est = '0;
    logic              arm_cur_neg = 1'b0;
    logic [N-1:0]      ins_mask_in = '0;
    logic [N-1:0]      oos_mask = '0;
    logic [CW-1:0]     req_cnt = '0;
    logic [N-1:0]      ins_mask_out;
    logic              sel_done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    arm_insert_selector #(.N_MOD(N), .VW(VW)) u0 (
        .clk, .rst_n, .upd_stb, .volt_est, .arm_cur_neg,
        .ins_mask_in, .oos_mask, .req_cnt, .ins_mask_out, .sel_done
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_volts(input int v0, v1, v2, v3, v4, v5, v6, v7);
        int v[8];
        v = '{v0, v1, v2, v3, v4, v5, v6, v7};
        for (int i = 0; i < N; i++) volt_est[i*VW +: VW] = VW'(v[i]);
    endtask

    task automatic run_update(input string tag, input logic [N-1:0] cur,
                              input logic [N-1:0] oos, input int req, input logic neg,
                              input logic [N-1:0] exp_mask, input int exp_lat);
        int lat;
        @(negedge clk);
        ins_mask_in = cur; oos_mask = oos; req_cnt = CW'(req); arm_cur_neg = neg;
        upd_stb = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        lat = 0;
        while (!sel_done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " mask"}, int'(ins_mask_out), int'(exp_mask));
        check({tag, " latency R1"}, lat, exp_lat);
    endtask

    task automatic t_reset();
        check("R10 reset mask", int'(ins_mask_out), 0);
        check("R10 reset done", int'(sel_done), 0);
    endtask

    task automatic t_busy_ignored();
        int lat;
        set_volts(100, 300, 200, 500, 400, 50, 700, 600);
        @(negedge clk);
        ins_mask_in = 8'h00; oos_mask = 8'h00; req_cnt = 3; arm_cur_neg = 1'b0;
        upd_stb = 1'b1;
        @(negedge clk);
        ins_mask_in = 8'hFF; req_cnt = 0; arm_cur_neg = 1'b1;
        @(negedge clk);
        upd_stb = 1'b0;
        lat = 1;
        while (!sel_done && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        check("R1 busy strobe ignored mask", int'(ins_mask_out), 8'h25);
        check("R1 busy strobe latency", lat, 4);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R1 done single", int'(sel_done), 0);
            check("R10 mask held", int'(ins_mask_out), 8'h25);
        end
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        set_volts(100, 300, 200, 500, 400, 50, 700, 600);
        // R2: no change in count
        run_update("R2 zero change", 8'h0F, 8'h00, 4, 1'b0, 8'h0F, 1);
        // R3: grow, positive current, lowest bypassed 5,0,2
        run_update("R3 grow low R11", 8'h00, 8'h00, 3, 1'b0, 8'h25, 4);
        // R4: grow, negative current, highest bypassed 6,7
        run_update("R4 grow high", 8'h01, 8'h00, 3, 1'b1, 8'hC1, 3);
        // R5: shrink, positive current, drop 6,7,3
        run_update("R5 shrink high", 8'hFF, 8'h00, 5, 1'b0, 8'h37, 4);
        // R6: shrink, negative current, drop 5,4
        run_update("R6 shrink low", 8'hF0, 8'h00, 2, 1'b1, 8'hC0, 3);
        // R7: equal voltages resolve to lowest index in both directions
        set_volts(100, 100, 100, 100, 100, 100, 100, 100);
        run_update("R7 tie low search", 8'h00, 8'h00, 2, 1'b0, 8'h03, 3);
        run_update("R7 tie high search", 8'h00, 8'h00, 2, 1'b1, 8'h03, 3);
        set_volts(100, 300, 200, 500, 400, 50, 700, 600);
        // R8: modules 0 and 5 unusable, next lowest are 2,1,4
        run_update("R8 skip oos", 8'h00, 8'h21, 3, 1'b0, 8'h16, 4);
        // R8: inserted module taken out of service is cleared, count unchanged
        run_update("R8 oos cleared R2", 8'h81, 8'h80, 1, 1'b0, 8'h01, 1);
        // R9: request of 8 with two modules unusable clamps to 6
        run_update("R9 clamp", 8'h00, 8'h03, 8, 1'b0, 8'hFC, 7);
        t_busy_ignored();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule